// File: doc/BRIEF.md
# Machine-Check Status Cloaking Controller

This block serves one logical thread. It keeps a small set of machine-check status banks and a 64-bit control register. The control register can be reached only while the thread runs in privileged management mode. It enables two features. The first hides corrected-error status from readers outside management mode: such a read returns zero, and the logged word stays as it was. The second raises a pending management-interrupt flag when an uncorrected error without context corruption is logged. The flag stays up until an acknowledge arrives.

Register reads are answered one cycle after the strobe, on a read-data bus and a one-cycle fault flag. Error logging runs on its own port and writes a full status word into a selected bank. Every instance has its own state, so a multi-thread design places one copy per thread.

Top module: `mca_cloak_ctrl`

## Requirements
- R1: After reset the control bits, all status banks, the read data, the fault flag and the pending flag are 0.
- R2: The control register sits at address 0x52, with cloak enable in bit 0 and interrupt enable in bit 9. A read in management mode returns these two bits and zeros everywhere else. Read data and the fault flag appear in the cycle after the strobe.
- R3: Any read or write of address 0x52 outside management mode raises the fault flag for one cycle, returns read data 0 and leaves the control bits unchanged.
- R4: A write to 0x52 in management mode that sets any bit in 63:10 or 8:1 raises the fault flag and leaves the control bits unchanged.
- R5: There are four status banks at addresses 0x401, 0x405, 0x409 and 0x40D. A log strobe stores the status word in the bank chosen by the bank index. A register write to a bank address stores the write data without a fault.
- R6: With cloak enabled, a read from outside management mode of a bank that holds a valid corrected word returns 0. A valid corrected word has bit 63 = 1, bit 61 = 0 and bit 57 = 0. The stored word is kept and can be read later in management mode.
- R7: Reads in management mode always return the stored word. Words that are not valid corrected words are never masked.
- R8: With interrupt enable set, logging a word with bit 63 = 1, bit 61 = 1 and bit 57 = 0 sets the pending flag in the next cycle. A word with bit 57 = 1, or a disabled feature, leaves the flag unchanged.
- R9: The pending flag holds until the acknowledge input is high at a clock edge. An acknowledge in the same cycle as a new qualifying log keeps the flag set.
- R10: A read of an unmapped address returns 0 without a fault. A write to an unmapped address changes no state and raises no fault.
- R11: When a log strobe and a register write target the same bank in the same cycle, the logged word is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_mode | input | 1 | High while the thread runs in management mode |
| reg_addr | input | 12 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the read strobe |
| reg_fault | output | 1 | General-protection fault, one cycle after the access |
| log_valid | input | 1 | Error-log strobe |
| log_bank | input | 2 | Bank index for the logged word |
| log_status | input | 64 | Status word to log |
| irq_pend | output | 1 | Pending management-interrupt flag |
| irq_ack | input | 1 | Clears the pending flag |

## Verification
A wrong control bit shows up at the first later management-mode read of 0x52. It also shows as read data that is wrongly masked or wrongly unmasked on the next read from outside management mode. A corrupted bank shows as wrong read data one cycle after the next read of that bank. A wrong pending flag is visible on the output in the cycle after the log event or the acknowledge. The reference model is compared on every clock, so each of these faults is caught within one cycle of the read or event that exposes it.

// File: rtl/mca_cloak_ctrl.sv
module mca_cloak_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int NBANK       = 4,
  parameter int BANK_STRIDE = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h052,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'h401,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_fault,
  input  logic              log_valid,
  input  logic [BW-1:0]     log_bank,
  input  logic [63:0]       log_status,
  output logic              irq_pend,
  input  logic              irq_ack
);

  localparam logic [63:0]       CTRL_KEEP = 64'h0000_0000_0000_0201;
  localparam logic [ADDR_W-1:0] STRIDE_A  = ADDR_W'(BANK_STRIDE);
  localparam logic [ADDR_W-1:0] NBANK_A   = ADDR_W'(NBANK);

  function automatic logic is_corr(input logic [63:0] w);
    return w[63] && !w[61] && !w[57];
  endfunction

  function automatic logic is_unc(input logic [63:0] w);
    return w[63] && w[61] && !w[57];
  endfunction

  logic [63:0] bank_q [NBANK];
  logic        cloak_q, irqen_q;
  logic [63:0] rdata_d;

  wire [ADDR_W-1:0] off     = reg_addr - BANK_BASE;
  wire              st_hit  = (reg_addr >= BANK_BASE) && ((off % STRIDE_A) == '0)
                              && ((off / STRIDE_A) < NBANK_A);
  wire [BW-1:0]     idx     = BW'(off / STRIDE_A);
  wire [63:0]       st_val  = bank_q[idx];
  wire              ctl_hit = (reg_addr == CTRL_ADDR);
  wire              priv_bad = ctl_hit && (reg_rd || reg_wr) && !mgmt_mode;
  wire              res_bad  = ctl_hit && reg_wr && mgmt_mode && |(reg_wdata & ~CTRL_KEEP);
  wire              fault_d  = priv_bad || res_bad;
  wire              ctl_we   = ctl_hit && reg_wr && mgmt_mode && !res_bad;
  wire              pend_d   = (irq_pend && !irq_ack) || (log_valid && irqen_q && is_unc(log_status));

  always_comb begin
    rdata_d = '0;
    if (reg_rd && !fault_d) begin
      if (ctl_hit)
        rdata_d = {54'b0, irqen_q, 8'b0, cloak_q};
      else if (st_hit)
        rdata_d = (cloak_q && !mgmt_mode && is_corr(st_val)) ? '0 : st_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cloak_q   <= 1'b0;
      irqen_q   <= 1'b0;
      reg_rdata <= '0;
      reg_fault <= 1'b0;
      irq_pend  <= 1'b0;
    end else begin
      if (ctl_we) begin
        cloak_q <= reg_wdata[0];
        irqen_q <= reg_wdata[9];
      end
      reg_rdata <= rdata_d;
      reg_fault <= fault_d;
      irq_pend  <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (!rst_n)
        bank_q[i] <= '0;
      else if (log_valid && log_bank == BW'(i))
        bank_q[i] <= log_status;
      else if (reg_wr && st_hit && idx == BW'(i))
        bank_q[i] <= reg_wdata;
    end
  end

  a_r3_priv_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && reg_wr && !mgmt_mode) |=> (reg_fault && $stable(cloak_q) && $stable(irqen_q)));

  a_r4_reserved_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && reg_wr && mgmt_mode && |reg_wdata[8:1]) |=> (reg_fault && $stable(irqen_q)));

  a_r2_ctrl_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && reg_rd && mgmt_mode) |=> (reg_rdata[63:10] == '0 && reg_rdata[8:1] == '0));

  a_r6_cloak_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && st_hit && !mgmt_mode && cloak_q && is_corr(st_val)) |=> (reg_rdata == '0));

  a_r7_mgmt_true: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && st_hit && mgmt_mode) |=> (reg_rdata == $past(st_val)));

  a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && irqen_q && is_unc(log_status)) |=> irq_pend);

  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend);

  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && !st_hit && !ctl_hit) |=> (!reg_fault && reg_rdata == '0));

endmodule

// File: tb/test_mca_cloak_ctrl.sv
module test_mca_cloak_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, mgmt_mode = 0;
  logic [11:0] reg_addr = '0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [63:0] reg_wdata = '0, log_status = '0;
  logic [63:0] reg_rdata;
  logic        reg_fault, irq_pend;
  logic        log_valid = 0, irq_ack = 0;
  logic [1:0]  log_bank = '0;

  mca_cloak_ctrl i_mca_cloak_ctrl (
    .clk(clk), .rst_n(rst_n), .mgmt_mode(mgmt_mode), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_fault(reg_fault), .log_valid(log_valid), .log_bank(log_bank),
    .log_status(log_status), .irq_pend(irq_pend), .irq_ack(irq_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    errors = 0, checks = 0;
  string tag = "R1";
  bit    started = 0;
  bit    done = 0;

  logic [63:0] mb [4];
  logic        m_cloak, m_irqen, m_fault, m_pend;
  logic [63:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mb[i] = '0;
      m_cloak = 0; m_irqen = 0; m_fault = 0; m_pend = 0; m_rdata = '0;
    end else begin
      logic [63:0] nrd, v;
      logic        nf, is_bank;
      int          bi;
      nrd = '0; nf = 0;
      is_bank = 0; bi = 0;
      for (int k = 0; k < 4; k++)
        if (reg_addr == 12'h401 + 12'(4*k)) begin is_bank = 1; bi = k; end
      if (reg_addr == 12'h052 && (reg_rd || reg_wr)) begin
        if (!mgmt_mode) nf = 1;
        else if (reg_wr && (reg_wdata & ~64'h201) != 0) nf = 1;
        if (reg_rd && !nf) nrd = {54'b0, m_irqen, 8'b0, m_cloak};
      end else if (is_bank && reg_rd) begin
        v = mb[bi];
        if (m_cloak && !mgmt_mode && v[63] && !v[61] && !v[57]) nrd = '0;
        else nrd = v;
      end
      m_pend = (m_pend && !irq_ack) ||
               (log_valid && m_irqen && log_status[63] && log_status[61] && !log_status[57]);
      if (reg_addr == 12'h052 && reg_wr && !nf) begin
        m_cloak = reg_wdata[0]; m_irqen = reg_wdata[9];
      end
      if (is_bank && reg_wr) mb[bi] = reg_wdata;
      if (log_valid) mb[log_bank] = log_status;
      m_rdata = nrd; m_fault = nf;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (reg_rdata !== m_rdata || reg_fault !== m_fault || irq_pend !== m_pend) begin
        errors++;
        $display("FAIL %s: rdata=%h fault=%b pend=%b expected rdata=%h fault=%b pend=%b",
                 tag, reg_rdata, reg_fault, irq_pend, m_rdata, m_fault, m_pend);
      end
    end
  end

  task automatic acc(input bit r, input bit w, input logic [11:0] a,
                     input logic [63:0] d, input bit s);
    reg_rd = r; reg_wr = w; reg_addr = a; reg_wdata = d; mgmt_mode = s;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    @(negedge clk);
  endtask

  task automatic lg(input logic [1:0] b, input logic [63:0] st);
    log_valid = 1; log_bank = b; log_status = st;
    @(negedge clk);
    log_valid = 0;
    @(negedge clk);
  endtask

  task automatic ack;
    irq_ack = 1; @(negedge clk); irq_ack = 0; @(negedge clk);
  endtask

  localparam logic [63:0] W_CE   = 64'h8000_0000_0000_00A5;
  localparam logic [63:0] W_UC   = 64'hA000_0000_0000_0011;
  localparam logic [63:0] W_UCP  = 64'hA200_0000_0000_0022;
  localparam logic [63:0] W_CEP  = 64'h8200_0000_0000_0044;
  localparam logic [63:0] W_INV  = 64'h0000_0000_0000_0033;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    for (int k = 0; k < 4; k++) acc(1, 0, 12'h401 + 12'(4*k), '0, 1);
    acc(1, 0, 12'h052, '0, 1);

    tag = "R2";
    acc(0, 1, 12'h052, 64'h201, 1);
    acc(1, 0, 12'h052, '0, 1);
    acc(0, 1, 12'h052, 64'h1, 1);
    acc(1, 0, 12'h052, '0, 1);

    tag = "R3";
    acc(1, 0, 12'h052, '0, 0);
    acc(0, 1, 12'h052, 64'h200, 0);
    acc(1, 0, 12'h052, '0, 1);

    tag = "R4";
    acc(0, 1, 12'h052, 64'h202, 1);
    acc(0, 1, 12'h052, 64'h1 << 40, 1);
    acc(0, 1, 12'h052, 64'h8000_0000_0000_0000, 1);
    acc(1, 0, 12'h052, '0, 1);

    tag = "R5";
    acc(0, 1, 12'h052, 64'h0, 1);
    lg(0, W_INV); lg(1, W_UC); lg(2, W_CE); lg(3, W_UCP);
    for (int k = 0; k < 4; k++) acc(1, 0, 12'h401 + 12'(4*k), '0, 0);
    acc(0, 1, 12'h409, 64'h1234_5678_9ABC_DEF0, 0);
    acc(1, 0, 12'h409, '0, 1);

    tag = "R6";
    acc(0, 1, 12'h052, 64'h1, 1);
    lg(0, W_CE);
    acc(1, 0, 12'h401, '0, 0);
    acc(1, 0, 12'h401, '0, 1);
    acc(0, 1, 12'h052, 64'h0, 1);
    acc(1, 0, 12'h401, '0, 0);
    acc(0, 1, 12'h052, 64'h1, 1);

    tag = "R7";
    lg(1, W_UC); lg(2, W_INV); lg(3, W_CEP);
    for (int k = 1; k < 4; k++) acc(1, 0, 12'h401 + 12'(4*k), '0, 0);
    for (int k = 0; k < 4; k++) acc(1, 0, 12'h401 + 12'(4*k), '0, 1);

    tag = "R8";
    lg(1, W_UC);
    acc(0, 1, 12'h052, 64'h200, 1);
    lg(2, W_UCP);
    lg(2, W_CE);
    lg(1, W_UC);
    ack();
    lg(3, W_INV);

    tag = "R9";
    lg(0, W_UC);
    repeat (3) @(negedge clk);
    irq_ack = 1; log_valid = 1; log_bank = 1; log_status = W_UC;
    @(negedge clk);
    irq_ack = 0; log_valid = 0;
    @(negedge clk);
    ack();
    repeat (2) @(negedge clk);

    tag = "R10";
    acc(1, 0, 12'h400, '0, 0);
    acc(1, 0, 12'h402, '0, 1);
    acc(1, 0, 12'h411, '0, 1);
    acc(0, 1, 12'h402, 64'hFFFF, 0);
    acc(0, 1, 12'h053, 64'hFFFF, 0);
    acc(1, 0, 12'h052, '0, 1);
    for (int k = 0; k < 4; k++) acc(1, 0, 12'h401 + 12'(4*k), '0, 1);

    tag = "R11";
    reg_wr = 1; reg_addr = 12'h405; reg_wdata = 64'h5555; mgmt_mode = 1;
    log_valid = 1; log_bank = 1; log_status = W_INV;
    @(negedge clk);
    reg_wr = 0; log_valid = 0;
    @(negedge clk);
    acc(1, 0, 12'h405, '0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule